// File: doc/BRIEF.md
# Table-Coded Arithmetic and Logic Unit

This block is a purely combinational arithmetic-logic unit for a small register-to-register datapath. It takes two operand words and a 6-bit operation code and returns one result word in the same cycle. The same word also carries a flag that says whether the code names a supported operation. The flag lets the surrounding pipeline tell a real operation apart from an empty slot, for example to gate a register write.

There are eleven operations: sum, difference, bitwise AND, OR and XOR, bitwise inversion of either operand, two's-complement negation of either operand, and the magnitude of either operand. The operation codes do not form a dense range. They are scattered values fixed by an assignment table. Operands are two's-complement. Every arithmetic result wraps modulo 2^DATA_W.

The block has no clock, so there is no stream handshake. A caller holds the operands and the code steady, and the result is valid after the combinational delay.

Top module: `opmap_alu`

## Requirements
- R1: Code 15 (binary 001111) gives opnd_a + opnd_b, wrapped modulo 2^32.
- R2: Code 8 (001000) gives opnd_a - opnd_b, wrapped modulo 2^32.
- R3: Code 2 (000010) gives the magnitude of opnd_a, and code 11 (001011) gives the magnitude of opnd_b. The magnitude of 0x80000000 is 0x80000000.
- R4: Code 3 (000011) gives the two's-complement negation of opnd_a (all bits inverted, plus one), and code 5 (000101) gives the same for opnd_b. The negation of 0 is 0.
- R5: Code 10 (001010) gives bitwise OR, code 4 (000100) gives bitwise AND, and code 14 (001110) gives bitwise XOR of the two operands.
- R6: Code 12 (001100) gives the bitwise inverse of opnd_a, and code 6 (000110) gives the bitwise inverse of opnd_b.
- R7: op_known is 1 exactly for the eleven codes listed in R1 to R6, and 0 for the other 53 codes.
- R8: For any code not listed in R1 to R6, alu_out is 0 whatever the operands are.
- R9: The outputs depend only on the present inputs. A change on any input shows on the outputs in the same cycle, and no earlier input affects them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand, two's-complement |
| opnd_b | input | 32 | Second operand, two's-complement |
| op_code | input | 6 | Operation code |
| alu_out | output | 32 | Result word |
| op_known | output | 1 | 1 when op_code names a supported operation |

## Verification
The bench sweeps all 64 codes over operand pairs that include 0, -1, the most positive and most negative values, and random words. This sweep catches a code shifted by one table row, and a code that aliases onto a neighbouring operation or leaves op_known set. Operands of 0x80000000 and 0x7FFFFFFF expose a magnitude step that saturates or tests the wrong sign bit, and a negation that forgets the increment. Sums and differences that cross the 32-bit wrap show a carry-in that was dropped or inverted. Undefined codes with non-zero operands show a result that leaks from a default branch instead of being forced to zero.

// File: rtl/opmap_alu_pkg.sv
package opmap_alu_pkg;

  localparam int OP_W = 6;

  // Operation code assignment (scattered table values)
  localparam logic [OP_W-1:0] OPC_ADD  = 6'd15;
  localparam logic [OP_W-1:0] OPC_SUB  = 6'd8;
  localparam logic [OP_W-1:0] OPC_ABSA = 6'd2;
  localparam logic [OP_W-1:0] OPC_NEGA = 6'd3;
  localparam logic [OP_W-1:0] OPC_ABSB = 6'd11;
  localparam logic [OP_W-1:0] OPC_NEGB = 6'd5;
  localparam logic [OP_W-1:0] OPC_OR   = 6'd10;
  localparam logic [OP_W-1:0] OPC_NOTA = 6'd12;
  localparam logic [OP_W-1:0] OPC_NOTB = 6'd6;
  localparam logic [OP_W-1:0] OPC_AND  = 6'd4;
  localparam logic [OP_W-1:0] OPC_XOR  = 6'd14;

  // Internal dense operation kind
  typedef enum logic [3:0] {
    K_NONE, K_ADD, K_SUB, K_ABSA, K_ABSB, K_NEGA, K_NEGB,
    K_OR, K_AND, K_XOR, K_NOTA, K_NOTB
  } alu_kind_e;

endpackage

// File: rtl/opmap_decode.sv
module opmap_decode
  import opmap_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output alu_kind_e       kind,
  output logic            known,
  output logic            use_arith
);

  always_comb begin
    unique case (op_code)
      OPC_ADD:  kind = K_ADD;
      OPC_SUB:  kind = K_SUB;
      OPC_ABSA: kind = K_ABSA;
      OPC_ABSB: kind = K_ABSB;
      OPC_NEGA: kind = K_NEGA;
      OPC_NEGB: kind = K_NEGB;
      OPC_OR:   kind = K_OR;
      OPC_AND:  kind = K_AND;
      OPC_XOR:  kind = K_XOR;
      OPC_NOTA: kind = K_NOTA;
      OPC_NOTB: kind = K_NOTB;
      default:  kind = K_NONE;
    endcase
  end

  always_comb begin
    known = (kind != K_NONE);
    unique case (kind)
      K_ADD, K_SUB, K_ABSA, K_ABSB, K_NEGA, K_NEGB: use_arith = 1'b1;
      default:                                       use_arith = 1'b0;
    endcase
  end

  // R7: a recognised code never selects arithmetic without being known
  always_comb begin
    if (use_arith) assert_arith_known_R7: assert (known)
      else $error("arith path selected for unknown code");
  end

endmodule

// File: rtl/opmap_arith.sv
module opmap_arith
  import opmap_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_kind_e         kind,
  output logic [DATA_W-1:0] sum
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] x, y;
  logic              cin;

  // One shared adder: every arithmetic kind is x + y + cin
  always_comb begin
    x   = '0;
    y   = '0;
    cin = 1'b0;
    unique case (kind)
      K_ADD: begin x = a; y = b; end
      K_SUB: begin x = a; y = ~b; cin = 1'b1; end
      K_NEGA: begin y = ~a; cin = 1'b1; end
      K_NEGB: begin y = ~b; cin = 1'b1; end
      K_ABSA: begin
        if (a[MSB]) begin y = ~a; cin = 1'b1; end
        else        x = a;
      end
      K_ABSB: begin
        if (b[MSB]) begin y = ~b; cin = 1'b1; end
        else        x = b;
      end
      default: ;
    endcase
  end

  assign sum = x + y + {{(DATA_W-1){1'b0}}, cin};

  // R2: difference plus subtrahend restores the minuend
  always_comb begin
    if (kind == K_SUB) assert_sub_inverse_R2: assert ((sum + b) == a)
      else $error("difference does not invert");
  end

  // R3: magnitude is non-negative except for the most negative input
  always_comb begin
    if (kind == K_ABSA && a != {1'b1, {(DATA_W-1){1'b0}}})
      assert_absa_sign_R3: assert (!sum[MSB]) else $error("negative magnitude");
    if (kind == K_ABSB && b != {1'b1, {(DATA_W-1){1'b0}}})
      assert_absb_sign_R3: assert (!sum[MSB]) else $error("negative magnitude");
  end

  // R4: a value and its negation cancel
  always_comb begin
    if (kind == K_NEGA) assert_nega_cancel_R4: assert ((sum + a) == '0)
      else $error("negation of a does not cancel");
    if (kind == K_NEGB) assert_negb_cancel_R4: assert ((sum + b) == '0)
      else $error("negation of b does not cancel");
  end

endmodule

// File: rtl/opmap_logic.sv
module opmap_logic
  import opmap_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_kind_e         kind,
  output logic [DATA_W-1:0] res
);

  logic [DATA_W-1:0] v_or, v_and;

  assign v_or  = a | b;
  assign v_and = a & b;

  always_comb begin
    unique case (kind)
      K_OR:    res = v_or;
      K_AND:   res = v_and;
      K_XOR:   res = a ^ b;
      K_NOTA:  res = ~a;
      K_NOTB:  res = ~b;
      default: res = '0;
    endcase
  end

  // R5: exclusive-or equals bits set in one operand but not both
  always_comb begin
    if (kind == K_XOR) assert_xor_form_R5: assert (res == (v_or & ~v_and))
      else $error("xor inconsistent with or/and");
  end

  // R6: an inverse shares no set bit with its operand
  always_comb begin
    if (kind == K_NOTA) assert_nota_disjoint_R6: assert ((res & a) == '0)
      else $error("inverse overlaps operand");
    if (kind == K_NOTB) assert_notb_disjoint_R6: assert ((res & b) == '0)
      else $error("inverse overlaps operand");
  end

endmodule

// File: rtl/opmap_alu.sv
module opmap_alu
  import opmap_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [OP_W-1:0]   op_code,
  output logic [DATA_W-1:0] alu_out,
  output logic              op_known
);

  alu_kind_e         kind;
  logic              use_arith;
  logic [DATA_W-1:0] arith_res, logic_res;

  opmap_decode u_decode (
    .op_code  (op_code),
    .kind     (kind),
    .known    (op_known),
    .use_arith(use_arith)
  );

  opmap_arith #(.DATA_W(DATA_W)) u_arith (
    .a   (opnd_a),
    .b   (opnd_b),
    .kind(kind),
    .sum (arith_res)
  );

  opmap_logic #(.DATA_W(DATA_W)) u_logic (
    .a   (opnd_a),
    .b   (opnd_b),
    .kind(kind),
    .res (logic_res)
  );

  always_comb begin
    if (!op_known)      alu_out = '0;
    else if (use_arith) alu_out = arith_res;
    else                alu_out = logic_res;
  end

  // R8: undefined codes produce a zero word
  always_comb begin
    if (!op_known) assert_undef_zero_R8: assert (alu_out == '0)
      else $error("undefined code leaks a result");
  end

endmodule

// File: tb/opmap_alu_tb.sv
module opmap_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a, opnd_b;
  logic [5:0]  op_code;
  logic [31:0] alu_out;
  logic        op_known;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  opmap_alu u_dut (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_code (op_code),
    .alu_out (alu_out),
    .op_known(op_known)
  );

  // Behavioural reference written from the requirements
  function automatic void ref_model(input int op, input logic [31:0] a, input logic [31:0] b,
                                    output logic [31:0] r, output logic k, output string tag);
    k = 1'b1;
    case (op)
      15: begin r = a + b; tag = "R1"; end
      8:  begin r = a - b; tag = "R2"; end
      2:  begin r = ($signed(a) < 0) ? (32'd0 - a) : a; tag = "R3"; end
      11: begin r = ($signed(b) < 0) ? (32'd0 - b) : b; tag = "R3"; end
      3:  begin r = 32'd0 - a; tag = "R4"; end
      5:  begin r = 32'd0 - b; tag = "R4"; end
      10: begin r = a | b; tag = "R5"; end
      4:  begin r = a & b; tag = "R5"; end
      14: begin r = a ^ b; tag = "R5"; end
      12: begin r = ~a; tag = "R6"; end
      6:  begin r = ~b; tag = "R6"; end
      default: begin r = 32'd0; k = 1'b0; tag = "R8"; end
    endcase
  endfunction

  task automatic apply_check(input int op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp_r;
    logic        exp_k;
    string       tag;
    @(negedge clk);
    op_code = op[5:0];
    opnd_a  = a;
    opnd_b  = b;
    #1;  // R9: outputs follow inputs within the same cycle
    ref_model(op, a, b, exp_r, exp_k, tag);
    n_cmp++;
    if (alu_out !== exp_r) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
               tag, op, a, b, alu_out, exp_r);
    end
    n_cmp++;
    if (op_known !== exp_k) begin
      n_bad++;
      $display("FAIL R7 op=%0d known actual=%b expected=%b", op, op_known, exp_k);
    end
  endtask

  initial begin : main
    logic [31:0] pats [8];
    pats[0] = 32'h0000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0000;
    pats[3] = 32'h7FFF_FFFF;
    pats[4] = 32'h0000_0001;
    pats[5] = 32'hA5A5_5A5A;
    pats[6] = 32'h8000_0001;
    pats[7] = 32'h1234_5678;
    op_code = 6'd0;
    opnd_a  = 32'd0;
    opnd_b  = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state check: idle code 0 gives zero, not known (R8, R7)
    @(negedge clk);
    n_cmp++;
    if (alu_out !== 32'd0 || op_known !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 idle actual=%h/%b expected=0/0", alu_out, op_known);
    end
    // full code sweep over corner operand pairs (R1..R8)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int op = 0; op < 64; op++)
          apply_check(op, pats[i], pats[j]);
    // random operands on every code
    for (int n = 0; n < 300; n++)
      for (int op = 0; op < 64; op++)
        apply_check(op, $urandom, $urandom);
    // R9: back-to-back changes with no settling cycle between them
    apply_check(15, 32'hFFFF_FFFF, 32'd1);
    apply_check(8,  32'd0, 32'd1);
    apply_check(2,  32'h8000_0000, 32'd0);
    apply_check(63, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    done = 1'b1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule